// File: doc/BRIEF.md
# Cooperative Context Rotation Unit

This unit performs a complete cooperative task switch for a small processor core in a single command. It keeps a shared list of saved contexts. Each entry holds a program counter plus the zero and carry flags. Up to four hardware tasks each own an independent ring over that list. A ring is described by a base slot, a top slot and a pointer.

When the core issues a switch, the unit does four things in the same clock:
- it stores the outgoing PC and flags at the ring's pointer;
- it advances the pointer, returning to the base after the top;
- it hands back the context held in the newly selected slot;
- it leaves the pointer on that slot.

Repeated switches therefore rotate round-robin through n = top - base + 1 tasks, and software keeps no bookkeeping of its own.

Software sets up a ring in two steps. It issues a bounds command, which also places the pointer on the base. It then preloads each slot with a task's start PC before the first switch. The fetch unit consumes the restored PC, and the flag logic consumes the restored flags. Neither lies within this block.

Top module: `ctx_rotator`

## Requirements
- R1: A switch (`sw_en` high with `cfg_en` low) writes `{cur_pc, cur_z, cur_c}` into the slot addressed by the selected task's pointer.
- R2: On a switch the selected task's pointer becomes `base` when it equals `top`, and otherwise becomes the pointer plus one, modulo 16.
- R3: One clock after a switch, `rst_vld` is high and `rst_pc`, `rst_z` and `rst_c` show the slot at the new pointer as it stood before that clock's writes. In every other cycle `rst_vld` is low and the three restore outputs keep their values.
- R4: A bounds command (`cfg_en` high) loads the selected task's base from `cfg_base` and its top from `cfg_top`, and sets its pointer to `cfg_base`.
- R5: A switch on a ring whose base equals its top returns the PC and flags that the same switch saved.
- R6: A preload (`pre_en` high) writes `{pre_pc, pre_z, pre_c}` to slot `pre_addr`. If a switch saves to that same slot in the same cycle, the switch's value is the one stored.
- R7: `task_id` (0 to 3) selects which of four independent base/top/pointer sets a command uses. All four rings share one list of 16 slots. `cur_ptr` shows the pointer of the selected task.
- R8: When `cfg_en` and `sw_en` are both high, the switch is ignored: nothing is saved, the pointer follows R4 only, and `rst_vld` stays low.
- R9: After reset all slots, bases, tops and pointers are zero, and `rst_vld`, `rst_pc`, `rst_z` and `rst_c` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_id | input | 2 | Selects the ring used by this cycle's command |
| cfg_en | input | 1 | Bounds command |
| cfg_base | input | 4 | New base slot |
| cfg_top | input | 4 | New top slot |
| pre_en | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload slot |
| pre_pc | input | 16 | Preload PC |
| pre_z | input | 1 | Preload zero flag |
| pre_c | input | 1 | Preload carry flag |
| sw_en | input | 1 | Switch command |
| cur_pc | input | 16 | Outgoing task PC |
| cur_z | input | 1 | Outgoing zero flag |
| cur_c | input | 1 | Outgoing carry flag |
| rst_vld | output | 1 | Restored context valid, one cycle after a switch |
| rst_pc | output | 16 | Restored PC |
| rst_z | output | 1 | Restored zero flag |
| rst_c | output | 1 | Restored carry flag |
| cur_ptr | output | 4 | Pointer of the selected task |

## Verification
A preload and a switch can touch the list in the same cycle. That is the case where the slot being preloaded is either the slot the switch saves into or the slot it restores from. The bench provokes both cases directly, and its random phase also produces them by drawing `pre_addr` near the active rings. It then judges the outcome from the reference model: the restore shows the old slot contents, and the save overrides the preload, which is visible when a later switch lands on that slot. A bounds command colliding with a switch is covered the same way, by checking that `rst_vld` stays low and that the pointer lands on the new base.

// File: rtl/ctx_rotator.sv
module ctx_rotator #(
  parameter int PC_W  = 16,
  parameter int SLOTS = 16,
  parameter int TASKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(TASKS)-1:0] task_id,
  input  logic                     cfg_en,
  input  logic [$clog2(SLOTS)-1:0] cfg_base,
  input  logic [$clog2(SLOTS)-1:0] cfg_top,
  input  logic                     pre_en,
  input  logic [$clog2(SLOTS)-1:0] pre_addr,
  input  logic [PC_W-1:0]          pre_pc,
  input  logic                     pre_z,
  input  logic                     pre_c,
  input  logic                     sw_en,
  input  logic [PC_W-1:0]          cur_pc,
  input  logic                     cur_z,
  input  logic                     cur_c,
  output logic                     rst_vld,
  output logic [PC_W-1:0]          rst_pc,
  output logic                     rst_z,
  output logic                     rst_c,
  output logic [$clog2(SLOTS)-1:0] cur_ptr
);
  localparam int AW = $clog2(SLOTS);
  localparam int EW = PC_W + 2;

  logic [EW-1:0] slot_q [SLOTS];
  logic [AW-1:0] base_q [TASKS];
  logic [AW-1:0] top_q  [TASKS];
  logic [AW-1:0] ptr_q  [TASKS];

  logic [AW-1:0] ptr_s, base_s, top_s, nxt;
  logic [EW-1:0] save_w, restored;
  logic          sw_go;

  assign ptr_s    = ptr_q[task_id];
  assign base_s   = base_q[task_id];
  assign top_s    = top_q[task_id];
  assign sw_go    = sw_en & ~cfg_en;
  assign nxt      = (ptr_s == top_s) ? base_s : AW'(ptr_s + 1'b1);
  assign save_w   = {cur_pc, cur_z, cur_c};
  assign restored = (nxt == ptr_s) ? save_w : slot_q[nxt];
  assign cur_ptr  = ptr_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
      for (int t = 0; t < TASKS; t++) begin
        base_q[t] <= '0;
        top_q[t]  <= '0;
        ptr_q[t]  <= '0;
      end
      rst_vld <= 1'b0;
      rst_pc  <= '0;
      rst_z   <= 1'b0;
      rst_c   <= 1'b0;
    end else begin
      if (pre_en) slot_q[pre_addr] <= {pre_pc, pre_z, pre_c};
      if (sw_go)  slot_q[ptr_s]    <= save_w;
      if (cfg_en) begin
        base_q[task_id] <= cfg_base;
        top_q[task_id]  <= cfg_top;
        ptr_q[task_id]  <= cfg_base;
      end else if (sw_go) begin
        ptr_q[task_id]  <= nxt;
      end
      rst_vld <= sw_go;
      if (sw_go) {rst_pc, rst_z, rst_c} <= restored;
    end
  end

  a_r1_save_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !cfg_en) |=> slot_q[$past(ptr_s)] == $past(save_w));

  a_r2_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !cfg_en && ptr_s == top_s) |=> ptr_q[$past(task_id)] == $past(base_s));

  a_r4_cfg_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> ptr_q[$past(task_id)] == $past(cfg_base));

  a_r5_single_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !cfg_en && base_s == top_s && ptr_s == top_s) |=> rst_pc == $past(cur_pc) && rst_vld);

  a_r8_cfg_blocks_sw: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> !rst_vld);

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> $stable(rst_pc) && !rst_vld);

endmodule

// File: tb/ctx_rotator_bench.sv
module ctx_rotator_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  task_id = 0;
  logic        cfg_en = 0, pre_en = 0, sw_en = 0;
  logic [3:0]  cfg_base = 0, cfg_top = 0, pre_addr = 0;
  logic [15:0] pre_pc = 0, cur_pc = 0;
  logic        pre_z = 0, pre_c = 0, cur_z = 0, cur_c = 0;
  logic        rst_vld, rst_z, rst_c;
  logic [15:0] rst_pc;
  logic [3:0]  cur_ptr;

  int vectors = 0, miscompares = 0;

  logic [17:0] m_slot [16];
  logic [3:0]  m_base [4];
  logic [3:0]  m_top  [4];
  logic [3:0]  m_ptr  [4];
  logic        e_vld;
  logic [17:0] e_rst;

  ctx_rotator u_ctx_rotator (.*);

  always #5 clk = ~clk;

  function automatic logic [3:0] next_ptr(logic [3:0] p, logic [3:0] b, logic [3:0] t);
    return (p == t) ? b : p + 4'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] p, n;
    logic [17:0] sv;
    p  = m_ptr[task_id];
    sv = {cur_pc, cur_z, cur_c};
    e_vld = sw_en && !cfg_en;
    if (e_vld) begin
      n = next_ptr(p, m_base[task_id], m_top[task_id]);
      e_rst = (n == p) ? sv : m_slot[n];
    end
    if (pre_en) m_slot[pre_addr] = {pre_pc, pre_z, pre_c};
    if (e_vld)  m_slot[p] = sv;
    if (cfg_en) begin
      m_base[task_id] = cfg_base; m_top[task_id] = cfg_top; m_ptr[task_id] = cfg_base;
    end else if (e_vld) m_ptr[task_id] = n;
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({req, " vld"}, 32'(rst_vld), 32'(e_vld));
    chk({req, " ctx"}, 32'({rst_pc, rst_z, rst_c}), 32'(e_rst));
    chk({req, " ptr"}, 32'(cur_ptr), 32'(m_ptr[task_id]));
    cfg_en = 0; pre_en = 0; sw_en = 0;
  endtask

  task automatic do_cfg(logic [1:0] t, logic [3:0] b, logic [3:0] tp);
    task_id = t; cfg_en = 1; cfg_base = b; cfg_top = tp;
    cycle("R4");
  endtask

  task automatic do_pre(logic [3:0] a, logic [15:0] pc, logic [1:0] f);
    pre_en = 1; pre_addr = a; pre_pc = pc; {pre_z, pre_c} = f;
    cycle("R6");
  endtask

  task automatic do_sw(string req, logic [1:0] t, logic [15:0] pc, logic [1:0] f);
    task_id = t; sw_en = 1; cur_pc = pc; {cur_z, cur_c} = f;
    cycle(req);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_slot[i] = '0;
    for (int t = 0; t < 4; t++) begin m_base[t] = 0; m_top[t] = 0; m_ptr[t] = 0; end
    e_vld = 0; e_rst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 vld", 32'(rst_vld), 0);
    chk("R9 ctx", 32'({rst_pc, rst_z, rst_c}), 0);
    chk("R9 ptr", 32'(cur_ptr), 0);

    // R4 R2 R1 R3: ring of three on task 0
    do_cfg(0, 4'd2, 4'd4);
    do_pre(4'd3, 16'h1003, 2'b01);
    do_pre(4'd4, 16'h1004, 2'b10);
    do_sw("R3", 0, 16'hA000, 2'b11);
    do_sw("R2", 0, 16'hA001, 2'b00);
    do_sw("R2 wrap", 0, 16'hA002, 2'b01);
    do_sw("R1", 0, 16'hA003, 2'b10);
    // R5 single slot ring on task 1
    do_cfg(1, 4'd7, 4'd7);
    do_sw("R5", 1, 16'hBEEF, 2'b10);
    do_sw("R5 again", 1, 16'hBEE0, 2'b01);
    // R7 task 0 unaffected by task 1
    task_id = 0; cycle("R7");
    // R6 collision: preload same slot as save, and as restore
    task_id = 0; sw_en = 1; cur_pc = 16'hC001; pre_en = 1; pre_addr = m_ptr[0]; pre_pc = 16'h5555;
    cycle("R6 save wins");
    task_id = 0; sw_en = 1; cur_pc = 16'hC002; pre_en = 1;
    pre_addr = next_ptr(m_ptr[0], m_base[0], m_top[0]); pre_pc = 16'h6666;
    cycle("R6 restore old");
    do_sw("R6 later", 0, 16'hC003, 2'b00);
    do_sw("R6 later2", 0, 16'hC004, 2'b00);
    // R8 cfg with switch
    task_id = 2; cfg_en = 1; cfg_base = 4'd9; cfg_top = 4'd12; sw_en = 1; cur_pc = 16'hDEAD;
    cycle("R8");
    do_sw("R8 nosave", 2, 16'h0009, 2'b00);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      task_id = 2'($urandom_range(0, 3));
      cfg_en = (r < 6);
      if (cfg_en) begin
        cfg_base = 4'($urandom_range(0, 15));
        cfg_top  = ($urandom_range(0, 9) == 0) ? cfg_base : 4'($urandom_range(0, 15));
      end
      sw_en  = (r >= 3) && (r < 70);
      pre_en = ($urandom_range(0, 3) == 0);
      pre_addr = ($urandom_range(0, 1) == 0) ? m_ptr[task_id] + 4'($urandom_range(0, 1))
                                             : 4'($urandom_range(0, 15));
      pre_pc = 16'($urandom); {pre_z, pre_c} = 2'($urandom);
      cur_pc = 16'($urandom); {cur_z, cur_c} = 2'($urandom);
      cycle("R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule